// File: doc/BRIEF.md
# Eight-Channel Inter-Core Mailbox

This block lets two processor cores exchange short messages through a set of independent channels. Each channel holds a 31-bit user field, four 32-bit payload words and two flags: data present and interrupt pending. A sender fills the payload and then writes the control word with bit 31 set. That single write stores the user field and raises both flags. The receiver reads the message and clears the flags by writing ones to the channel's status register. Clearing the data-present flag also frees the channel for the next message.

A packed status word shows the flags of every channel at once. A split mask register gates each channel's pending interrupt separately toward each of the two cores. Each core receives one interrupt line that merges its unmasked channels. Register access uses a simple single-cycle bus: a write takes effect at the clock edge where it is requested, and read data is returned one cycle after the request.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, every user field, payload word and flag is zero. Every mask bit is one (blocked). Both interrupt outputs are low, and `bus_rvalid` and `bus_rdata` are zero.
- R2: Channel c owns the byte window starting at c*0x20, with word offsets ctrl 0x00, payload 0x04/0x08/0x0C/0x10 and status 0x14. The packed status word is at 0x100 and the mask is at 0x104. Address bits [1:0] are ignored. Every other address reads zero, and writes to it change nothing.
- R3: A read request (`bus_valid` high, `bus_write` low) returns its data on `bus_rdata` with `bus_rvalid` high in the following cycle. In any cycle not following a read, both outputs are zero.
- R4: A payload word reads back the last value written to it.
- R5: A control write stores bits [30:0] as the user field. If bit 31 of the written data is 1, the write also sets data-present and interrupt-pending. If bit 31 is 0, both flags are left unchanged.
- R6: The channel status word reads {30'b0, data_present, irq_pending}, so bit 1 is data-present and bit 0 is interrupt-pending. Writing 1 to either bit clears that flag alone. Writing 0 to a bit leaves that flag unchanged.
- R7: Control bit 31 reads as the data-present flag. When the receiver clears data-present, bit 31 reads 0 and the user field is kept.
- R8: Packed status bits [2i+1:2i] equal channel i's status bits [1:0]. The upper bits read zero.
- R9: The mask register is 16 bits and can be read back. Bits [7:0] gate channels 0 to 7 toward core 0, and bits [15:8] gate them toward core 1. A 1 blocks.
- R10: `irq_core0` is the OR over all channels of (pending AND NOT mask bit i). `irq_core1` is the same using mask bit 8+i. Both follow register state in the cycle after the write that changes it.
- R11: A trigger write to a channel whose data is still present overwrites the user field, and the flags stay set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| irq_core0 | output | 1 | Merged interrupt toward core 0 |
| irq_core1 | output | 1 | Merged interrupt toward core 1 |

## Verification
A behavioural model in the bench predicts every output on every clock. It is driven through several message patterns.

- **One channel, one unmasked core.** A single channel is triggered with only one core unmasked. This shows whether the mask halves are routed to the correct interrupt line.
- **Partial acknowledge.** Only the pending flag is cleared, and then only data-present. This separates the two flags from each other and from control bit 31.
- **Control write without the trigger bit.** The user field changes and the flags do not.
- **Retrigger while data is present.** A channel is triggered again before it is acknowledged.
- **All channels at once.** Every channel is triggered together. This fills the packed status word, exposing any channel-to-bit misplacement.

Unmapped offsets inside a channel window and past the mask register are written and read back, to catch decode aliasing.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
   localparam int WORD_W    = 32;
   localparam int PAYLOAD_N = 4;
   localparam int CH_STRIDE = 32;
   localparam int CH_LSB    = $clog2(CH_STRIDE);
   localparam int SEL_W     = CH_LSB - 2;
   localparam int SEL_CTRL  = 0;
   localparam int SEL_STAT  = PAYLOAD_N + 1;

   typedef struct packed {
      logic dp;   // data present, status bit 1
      logic ip;   // interrupt pending, status bit 0
   } ch_flags_t;
endpackage

// File: rtl/ipc_mbox_channel.sv
module ipc_mbox_channel
   import ipc_mbox_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  sel,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rd_word,
   output ch_flags_t         flags
);
   if ((SEL_STAT + 1) * 4 > CH_STRIDE) begin : g_bad_stride
      $error("channel window too small for payload");
   end

   logic [WORD_W-2:0] user_q;
   logic [WORD_W-1:0] pay_q [PAYLOAD_N];

   wire ctrl_hit = wr_en && (sel == SEL_W'(SEL_CTRL));
   wire stat_hit = wr_en && (sel == SEL_W'(SEL_STAT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         user_q <= '0;
         flags  <= '0;
      end else if (ctrl_hit) begin
         user_q <= wdata[WORD_W-2:0];
         if (wdata[WORD_W-1]) flags <= '{dp: 1'b1, ip: 1'b1};
      end else if (stat_hit) begin
         if (wdata[0]) flags.ip <= 1'b0;
         if (wdata[1]) flags.dp <= 1'b0;
      end
   end

   for (genvar k = 0; k < PAYLOAD_N; k++) begin : g_pay
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              pay_q[k] <= '0;
         else if (wr_en && sel == SEL_W'(k + 1))  pay_q[k] <= wdata;
      end
   end

   always_comb begin
      rd_word = '0;
      if (sel == SEL_W'(SEL_CTRL))      rd_word = {flags.dp, user_q};
      else if (sel == SEL_W'(SEL_STAT)) rd_word = {{(WORD_W-2){1'b0}}, flags.dp, flags.ip};
      else begin
         for (int k = 0; k < PAYLOAD_N; k++)
            if (sel == SEL_W'(k + 1)) rd_word = pay_q[k];
      end
   end

   AST_TRIG_SETS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_hit && wdata[WORD_W-1] |=> flags.dp && flags.ip); // R5
   AST_ACK_CLEARS_DP: assert property (@(posedge clk) disable iff (!rst_n)
      stat_hit && wdata[1] |=> !flags.dp && !rd_word[WORD_W-1] || sel != SEL_W'(SEL_CTRL)); // R7
   AST_ZERO_ACK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      stat_hit && wdata[1:0] == 2'b00 |=> $stable(flags)); // R6
endmodule

// File: rtl/ipc_mbox_irq.sv
module ipc_mbox_irq #(
   parameter int NUM_CH = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_CH-1:0]   pend,
   input  logic [2*NUM_CH-1:0] mask,
   output logic [1:0]          irq
);
   for (genvar d = 0; d < 2; d++) begin : g_core
      wire [NUM_CH-1:0] gate = mask[d*NUM_CH +: NUM_CH];
      assign irq[d] = |(pend & ~gate);

      AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
         (&gate) |-> !irq[d]); // R9
   end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
   import ipc_mbox_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_rvalid,
   output logic              irq_core0,
   output logic              irq_core1
);
   localparam int CH_IDX_W = $clog2(NUM_CH);
   localparam int GLB_BASE = NUM_CH * CH_STRIDE;
   localparam int MASK_W   = 2 * NUM_CH;

   if (NUM_CH < 2 || NUM_CH > 16 || (1 << CH_IDX_W) != NUM_CH) begin : g_bad_ch
      $error("NUM_CH must be a power of two from 2 to 16");
   end
   if (GLB_BASE + 8 > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for register map");
   end

   wire                in_ch   = int'(bus_addr) < GLB_BASE;
   wire [CH_IDX_W-1:0] ch_idx  = bus_addr[CH_LSB +: CH_IDX_W];
   wire [SEL_W-1:0]    sel     = bus_addr[CH_LSB-1:2];
   wire                sel_ok  = int'(sel) <= SEL_STAT;
   wire                hit_sts = {bus_addr[ADDR_W-1:2], 2'b00} == ADDR_W'(GLB_BASE);
   wire                hit_msk = {bus_addr[ADDR_W-1:2], 2'b00} == ADDR_W'(GLB_BASE + 4);
   wire                wr      = bus_valid && bus_write;
   wire                rd      = bus_valid && !bus_write;

   ch_flags_t          flags  [NUM_CH];
   logic [WORD_W-1:0]  ch_rd  [NUM_CH];
   logic [NUM_CH-1:0]  pend;
   logic [31:0]        all_sts;
   logic [MASK_W-1:0]  mask_q;
   logic [1:0]         irq;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      ipc_mbox_channel u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr && in_ch && sel_ok && ch_idx == CH_IDX_W'(c)),
         .sel     (sel),
         .wdata   (bus_wdata),
         .rd_word (ch_rd[c]),
         .flags   (flags[c])
      );
      assign pend[c] = flags[c].ip;
   end

   always_comb begin
      all_sts = '0;
      for (int i = 0; i < NUM_CH; i++) all_sts[2*i +: 2] = {flags[i].dp, flags[i].ip};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              mask_q <= '1;
      else if (wr && hit_msk)  mask_q <= bus_wdata[MASK_W-1:0];
   end

   logic [31:0] rd_next;
   always_comb begin
      rd_next = '0;
      if (in_ch)        rd_next = sel_ok ? ch_rd[ch_idx] : '0;
      else if (hit_sts) rd_next = all_sts;
      else if (hit_msk) rd_next = 32'(mask_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
      end else begin
         bus_rdata  <= rd ? rd_next : '0;
         bus_rvalid <= rd;
      end
   end

   ipc_mbox_irq #(.NUM_CH(NUM_CH)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .pend  (pend),
      .mask  (mask_q),
      .irq   (irq)
   );
   assign irq_core0 = irq[0];
   assign irq_core1 = irq[1];

   AST_RVALID_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> bus_rvalid); // R3
   AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> !bus_rvalid && bus_rdata == '0); // R3
   AST_NO_PEND_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      pend == '0 |-> !irq_core0 && !irq_core1); // R10
endmodule

// File: tb/ipc_mailbox_test.sv
module ipc_mailbox_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid, irq_core0, irq_core1;

   int vectors = 0;
   int miscompares = 0;

   // reference model state
   logic [31:0] m_pay  [8][4];
   logic [30:0] m_user [8];
   logic        m_dp   [8];
   logic        m_ip   [8];
   logic [15:0] m_mask;

   always #(CLK_PERIOD/2) clk = ~clk;

   ipc_mailbox uut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .irq_core0(irq_core0), .irq_core1(irq_core1)
   );

   function automatic logic [31:0] model_read(input logic [11:0] a);
      int c, w;
      logic [31:0] v;
      v = '0;
      if (a < 12'h100) begin
         c = int'(a) / 32;
         w = (int'(a) % 32) / 4;
         if (w == 0)      v = {m_dp[c], m_user[c]};
         else if (w <= 4) v = m_pay[c][w-1];
         else if (w == 5) v = {30'b0, m_dp[c], m_ip[c]};
      end else if (a[11:2] == 10'h040) begin
         for (int i = 0; i < 8; i++) begin
            v[2*i]   = m_ip[i];
            v[2*i+1] = m_dp[i];
         end
      end else if (a[11:2] == 10'h041) begin
         v = {16'b0, m_mask};
      end
      return v;
   endfunction

   task automatic model_write(input logic [11:0] a, input logic [31:0] d);
      int c, w;
      if (a < 12'h100) begin
         c = int'(a) / 32;
         w = (int'(a) % 32) / 4;
         if (w == 0) begin
            m_user[c] = d[30:0];
            if (d[31]) begin m_dp[c] = 1'b1; m_ip[c] = 1'b1; end
         end else if (w <= 4) m_pay[c][w-1] = d;
         else if (w == 5) begin
            if (d[0]) m_ip[c] = 1'b0;
            if (d[1]) m_dp[c] = 1'b0;
         end
      end else if (a[11:2] == 10'h041) m_mask = d[15:0];
   endtask

   function automatic logic model_irq(input int core);
      logic r;
      r = 1'b0;
      for (int i = 0; i < 8; i++) r |= m_ip[i] & ~m_mask[core*8 + i];
      return r;
   endfunction

   task automatic step(input logic v, input logic w, input logic [11:0] a,
                       input logic [31:0] d, input string tag);
      logic [31:0] e_rdata;
      logic        e_rvalid;
      logic        bad;
      @(negedge clk);
      bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
      e_rvalid = v && !w;
      e_rdata  = e_rvalid ? model_read(a) : 32'h0;
      if (v && w) model_write(a, d);
      @(posedge clk);
      #1;
      bad = 1'b0;
      vectors++;
      if (bus_rvalid !== e_rvalid) begin
         $display("FAIL %s rvalid addr=%h actual=%b expected=%b", tag, a, bus_rvalid, e_rvalid); bad = 1'b1;
      end
      if (bus_rdata !== e_rdata) begin
         $display("FAIL %s rdata addr=%h actual=%h expected=%h", tag, a, bus_rdata, e_rdata); bad = 1'b1;
      end
      if (irq_core0 !== model_irq(0)) begin
         $display("FAIL %s irq_core0 actual=%b expected=%b", tag, irq_core0, model_irq(0)); bad = 1'b1;
      end
      if (irq_core1 !== model_irq(1)) begin
         $display("FAIL %s irq_core1 actual=%b expected=%b", tag, irq_core1, model_irq(1)); bad = 1'b1;
      end
      if (bad) miscompares++;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
      step(1'b1, 1'b1, a, d, tag);
   endtask
   task automatic rd(input logic [11:0] a, input string tag);
      step(1'b1, 1'b0, a, 32'h0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      for (int c = 0; c < 8; c++) begin
         m_user[c] = '0; m_dp[c] = 1'b0; m_ip[c] = 1'b0;
         for (int k = 0; k < 4; k++) m_pay[c][k] = '0;
      end
      m_mask = 16'hFFFF;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset values
      vectors++;
      if (bus_rvalid !== 1'b0 || bus_rdata !== 32'h0 || irq_core0 !== 1'b0 || irq_core1 !== 1'b0) begin
         miscompares++;
         $display("FAIL R1 reset outputs actual=%b/%h/%b/%b expected=0/0/0/0",
                  bus_rvalid, bus_rdata, irq_core0, irq_core1);
      end
      @(negedge clk) rst_n = 1'b1;
      step(1'b0, 1'b0, 12'h0, 32'h0, "R1");
      rd(12'h104, "R1");
      rd(12'h100, "R1");
      rd(12'h060, "R1");

      // R4 payload and R2 window decode
      wr(12'h064, 32'hA5A5_0001, "R4");
      wr(12'h068, 32'h5A5A_0002, "R4");
      wr(12'h06C, 32'hDEAD_BEEF, "R4");
      wr(12'h073, 32'h0BAD_F00D, "R2");   // low bits ignored -> 0x70
      rd(12'h064, "R4"); rd(12'h068, "R4"); rd(12'h06C, "R4"); rd(12'h070, "R2");
      wr(12'h078, 32'hFFFF_FFFF, "R2");
      rd(12'h078, "R2"); rd(12'h07C, "R2");
      wr(12'h108, 32'h1234_5678, "R2");
      rd(12'h108, "R2"); rd(12'h1FC, "R2");
      rd(12'h044, "R2");

      // R5 trigger, masked
      wr(12'h060, 32'h8000_1234, "R5");
      rd(12'h060, "R5"); rd(12'h074, "R6"); rd(12'h100, "R8");
      // R9/R10 unmask ch3 to core0, ch5 to core1
      wr(12'h104, 32'h0000_DFF7, "R9");
      rd(12'h104, "R9");
      wr(12'h0A0, 32'h8000_0055, "R10");
      rd(12'h100, "R8");
      // R6 clear pending only on ch3
      wr(12'h074, 32'h0000_0001, "R6");
      rd(12'h074, "R6"); rd(12'h060, "R7");
      // R6 zero write on ch5
      wr(12'h0B4, 32'h0000_0000, "R6");
      rd(12'h0B4, "R6");
      // R7 clear data present on ch3
      wr(12'h074, 32'h0000_0002, "R7");
      rd(12'h060, "R7"); rd(12'h074, "R7");
      // R5 control write without trigger
      wr(12'h0A0, 32'h0000_0777, "R5");
      rd(12'h0A0, "R5"); rd(12'h0B4, "R5");
      // R11 retrigger while data present
      wr(12'h0A0, 32'hC000_0099, "R11");
      rd(12'h0A0, "R11"); rd(12'h0B4, "R11");
      wr(12'h0B4, 32'h0000_0003, "R6");

      // R8 all channels, R10 every gate
      for (int c = 0; c < 8; c++) wr(12'(c*32), 32'h8000_0000 | 32'(c), "R8");
      rd(12'h100, "R8");
      for (int b = 0; b < 16; b++) wr(12'h104, ~(32'h1 << b), "R10");
      wr(12'h104, 32'h0000_0000, "R10");
      for (int c = 0; c < 8; c++) begin
         wr(12'(c*32 + 20), 32'h1, "R10");
         rd(12'h100, "R8");
      end
      for (int c = 0; c < 8; c++) wr(12'(c*32 + 20), 32'h2, "R7");
      rd(12'h100, "R8");
      for (int c = 0; c < 8; c++) rd(12'(c*32), "R7");

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule